// File: doc/BRIEF.md
# Configuration Frame Scrubbing Controller

This block keeps a frame-organised configuration memory clean while the logic that the memory configures keeps running. It visits the frames one after another. For each frame it reads every word back and compares it with the matching word of a golden image held in a separate reference memory. If any word differs, it rewrites the whole frame from the golden image and then reads the frame again to confirm the repair. Frames that compare clean are never written.

Software drives the block through a small register window. It can start one pass or run passes back to back, stop the block, and move it into a flash-load or direct-access mode. In those two modes scrubbing is held off. The same window reports progress, how many frames were repaired, the last frame found damaged, a sticky flag for frames that could not be repaired, and the length of the last complete pass in clock cycles.

The configuration memory is reached through a word port with a request and grant handshake. The frame and word address on that port also addresses the golden memory, which must answer combinationally.

Top module: `frame_scrubber`

## Requirements
- R1: The register window uses these offsets: 0 is control, 1 is status (bit0 busy, bit1 unrepaired flag), 2 is the current frame, 3 is the repair count, 4 is the last damaged frame and 5 is the pass length. After reset every register reads 0 and no memory request is made.
- R2: Writing control with bit0 = 1 while bits 3:2 = 0 (scrub mode) and the block is idle starts a pass at frame 0. The pass visits frames 0 to NUM_FRAMES-1 in rising order. With bit1 = 0 (single pass) the block goes idle after the last frame, and the current-frame register then reads NUM_FRAMES-1.
- R3: Each frame is read one word at a time and compared with the golden word at the same address. A frame with at least one differing word is rewritten in full, FRAME_WORDS writes, from the golden image. A clean frame receives no write.
- R4: After a rewrite the frame is read again. If it now matches, the repair count goes up by one and stops at 2^CNT_W-1. The repair count never decreases. Every frame found damaged on its first read is stored as the last damaged frame.
- R5: If the frame still differs after the rewrite, status bit1 is set and stays set. That frame is not written again in the same pass, and the repair count does not change. Status bit1 is cleared when a start is accepted.
- R6: With control bit1 = 1 (continuous), the next pass begins at frame 0 straight after the last frame, and busy stays high.
- R7: Writing control with bit4 = 1 (stop), or changing bits 3:2 away from scrub mode, ends the run only at a frame boundary. A frame is either fully rewritten or not touched, and busy then falls.
- R8: A start written while bits 3:2 select flash mode (1) or direct mode (2) is ignored. The block makes no memory request, and busy stays 0.
- R9: The pass-length register holds the number of cycles of the last completed pass, counted from its first read cycle to the boundary cycle of its last frame. With a memory that grants every request at once, this is NUM_FRAMES*(FRAME_WORDS+1) + 2*FRAME_WORDS*d, where d is the number of damaged frames.
- R10: A pending request keeps its address and write flag stable until it is granted. A word counts as done only in a cycle where the grant is high, so stalls change only the timing, not the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| cfg_req_o | output | 1 | Configuration memory request |
| cfg_we_o | output | 1 | Request is a write |
| cfg_frame_o | output | FRAME_W | Frame address, shared with the golden memory |
| cfg_word_o | output | WORD_W | Word within the frame, shared with the golden memory |
| cfg_wdata_o | output | DATA_W | Write data |
| cfg_gnt_i | input | 1 | Grant; read data is valid in this cycle |
| cfg_rdata_i | input | DATA_W | Configuration read data |
| gold_rdata_i | input | DATA_W | Golden word at the current address |

## Verification
The hardest case to reach is a frame that stays wrong after its own rewrite. A correct memory model always takes the golden data. To get there, the bench adds a stuck bit to the read path of one chosen frame, so the second read disagrees again. A second hard case is a stop that arrives in the middle of a rewrite. The bench damages every word of every frame, then stops a continuous run after a random delay. Each frame must then be either fully repaired or fully untouched, with no partly rewritten frame.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_VERIFY,
    ST_NEXT
  } scrub_state_e;

  typedef enum logic [1:0] {
    MODE_SCRUB  = 2'd0,
    MODE_FLASH  = 2'd1,
    MODE_DIRECT = 2'd2,
    MODE_RSVD   = 2'd3
  } op_mode_e;

  localparam logic [2:0] REG_CTRL     = 3'd0;
  localparam logic [2:0] REG_STATUS   = 3'd1;
  localparam logic [2:0] REG_CUR      = 3'd2;
  localparam logic [2:0] REG_FIXES    = 3'd3;
  localparam logic [2:0] REG_LAST_BAD = 3'd4;
  localparam logic [2:0] REG_PASS     = 3'd5;

  typedef struct packed {
    logic     start;
    logic     stop;
    logic     cont;
    op_mode_e mode;
  } ctrl_t;

  typedef struct packed {
    logic start_acc;
    logic pass_start;
    logic pass_end;
    logic bad_found;
    logic fixed;
    logic unfixed;
  } seq_evt_t;

endpackage

// File: rtl/scrub_regs.sv
module scrub_regs
  import scrub_pkg::*;
#(
  parameter int unsigned FRAME_W = 7,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TIME_W  = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         reg_addr_i,
  input  logic               reg_we_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic               busy_i,
  input  logic               unfixed_i,
  input  logic [FRAME_W-1:0] cur_frame_i,
  input  logic [CNT_W-1:0]   fix_cnt_i,
  input  logic [FRAME_W-1:0] last_bad_i,
  input  logic [TIME_W-1:0]  pass_cycles_i,
  output ctrl_t              ctrl_o
);

  logic     start_q, stop_q, cont_q;
  op_mode_e mode_q;
  logic     ctrl_wr;
  logic     unused_wdata;

  assign ctrl_wr      = reg_we_i && (reg_addr_i == REG_CTRL);
  assign unused_wdata = ^reg_wdata_i[31:5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      cont_q  <= 1'b0;
      mode_q  <= MODE_SCRUB;
    end else begin
      start_q <= ctrl_wr & reg_wdata_i[0];
      stop_q  <= ctrl_wr & reg_wdata_i[4];
      if (ctrl_wr) begin
        cont_q <= reg_wdata_i[1];
        mode_q <= op_mode_e'(reg_wdata_i[3:2]);
      end
    end
  end

  assign ctrl_o = '{start: start_q, stop: stop_q, cont: cont_q, mode: mode_q};

  always_comb begin
    unique case (reg_addr_i)
      REG_CTRL:     reg_rdata_o = {28'd0, mode_q, cont_q, 1'b0};
      REG_STATUS:   reg_rdata_o = {30'd0, unfixed_i, busy_i};
      REG_CUR:      reg_rdata_o = 32'(cur_frame_i);
      REG_FIXES:    reg_rdata_o = 32'(fix_cnt_i);
      REG_LAST_BAD: reg_rdata_o = 32'(last_bad_i);
      REG_PASS:     reg_rdata_o = 32'(pass_cycles_i);
      default:      reg_rdata_o = 32'd0;
    endcase
  end

endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
  import scrub_pkg::*;
#(
  parameter int unsigned NUM_FRAMES  = 96,
  parameter int unsigned FRAME_WORDS = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned FRAME_W     = $clog2(NUM_FRAMES),
  parameter int unsigned WORD_W      = $clog2(FRAME_WORDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ctrl_t              ctrl_i,
  output logic               cfg_req_o,
  output logic               cfg_we_o,
  output logic [FRAME_W-1:0] cfg_frame_o,
  output logic [WORD_W-1:0]  cfg_word_o,
  output logic [DATA_W-1:0]  cfg_wdata_o,
  input  logic               cfg_gnt_i,
  input  logic [DATA_W-1:0]  cfg_rdata_i,
  input  logic [DATA_W-1:0]  gold_rdata_i,
  output logic               busy_o,
  output logic               at_bnd_o,
  output seq_evt_t           evt_o
);

  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(NUM_FRAMES - 1);
  localparam logic [WORD_W-1:0]  LAST_WORD  = WORD_W'(FRAME_WORDS - 1);

  scrub_state_e       state_q, state_d;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [WORD_W-1:0]  word_q, word_d;
  logic               mism_q, mism_d;
  logic               stop_pend_q, stop_pend_d;

  logic ack, word_bad, frame_bad, last_word, last_frame, halt, start_ok;

  assign ack        = cfg_req_o & cfg_gnt_i;
  assign word_bad   = cfg_rdata_i != gold_rdata_i;
  assign frame_bad  = mism_q | word_bad;
  assign last_word  = word_q == LAST_WORD;
  assign last_frame = frame_q == LAST_FRAME;
  assign halt       = stop_pend_q | (ctrl_i.mode != MODE_SCRUB);
  assign start_ok   = (state_q == ST_IDLE) && ctrl_i.start && (ctrl_i.mode == MODE_SCRUB);

  always_comb begin
    state_d     = state_q;
    frame_d     = frame_q;
    word_d      = word_q;
    mism_d      = mism_q;
    stop_pend_d = stop_pend_q | (ctrl_i.stop & (state_q != ST_IDLE));
    evt_o       = '0;
    unique case (state_q)
      ST_IDLE: begin
        stop_pend_d = 1'b0;
        if (start_ok) begin
          state_d          = ST_READ;
          frame_d          = '0;
          word_d           = '0;
          mism_d           = 1'b0;
          evt_o.start_acc  = 1'b1;
          evt_o.pass_start = 1'b1;
        end
      end
      ST_READ: if (ack) begin
        mism_d = frame_bad;
        if (last_word) begin
          word_d = '0;
          mism_d = 1'b0;
          if (frame_bad) begin
            evt_o.bad_found = 1'b1;
            state_d         = ST_WRITE;
          end else begin
            state_d = ST_NEXT;
          end
        end else begin
          word_d = word_q + WORD_W'(1);
        end
      end
      ST_WRITE: if (ack) begin
        if (last_word) begin
          word_d  = '0;
          state_d = ST_VERIFY;
        end else begin
          word_d = word_q + WORD_W'(1);
        end
      end
      ST_VERIFY: if (ack) begin
        mism_d = frame_bad;
        if (last_word) begin
          word_d        = '0;
          mism_d        = 1'b0;
          evt_o.unfixed = frame_bad;
          evt_o.fixed   = !frame_bad;
          state_d       = ST_NEXT;
        end else begin
          word_d = word_q + WORD_W'(1);
        end
      end
      ST_NEXT: begin
        evt_o.pass_end = last_frame;
        if (halt) begin
          state_d     = ST_IDLE;
          stop_pend_d = 1'b0;
        end else if (last_frame) begin
          if (ctrl_i.cont) begin
            frame_d          = '0;
            state_d          = ST_READ;
            evt_o.pass_start = 1'b1;
          end else begin
            state_d     = ST_IDLE;
            stop_pend_d = 1'b0;
          end
        end else begin
          frame_d = frame_q + FRAME_W'(1);
          state_d = ST_READ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      frame_q     <= '0;
      word_q      <= '0;
      mism_q      <= 1'b0;
      stop_pend_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      frame_q     <= frame_d;
      word_q      <= word_d;
      mism_q      <= mism_d;
      stop_pend_q <= stop_pend_d;
    end
  end

  assign cfg_req_o   = (state_q == ST_READ) || (state_q == ST_WRITE) || (state_q == ST_VERIFY);
  assign cfg_we_o    = state_q == ST_WRITE;
  assign cfg_frame_o = frame_q;
  assign cfg_word_o  = word_q;
  assign cfg_wdata_o = gold_rdata_i;
  assign busy_o      = state_q != ST_IDLE;
  assign at_bnd_o    = state_q == ST_NEXT;

endmodule

// File: rtl/scrub_log.sv
module scrub_log
  import scrub_pkg::*;
#(
  parameter int unsigned FRAME_W = 7,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TIME_W  = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  seq_evt_t           evt_i,
  input  logic               busy_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [CNT_W-1:0]   fix_cnt_o,
  output logic [FRAME_W-1:0] last_bad_o,
  output logic               unfixed_o,
  output logic [TIME_W-1:0]  pass_cycles_o
);

  logic [TIME_W-1:0] timer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q       <= '0;
      pass_cycles_o <= '0;
      fix_cnt_o     <= '0;
      last_bad_o    <= '0;
      unfixed_o     <= 1'b0;
    end else begin
      if (evt_i.pass_start)  timer_q <= '0;
      else if (busy_i)       timer_q <= timer_q + TIME_W'(1);
      if (evt_i.pass_end)    pass_cycles_o <= timer_q + TIME_W'(1);
      if (evt_i.fixed && (fix_cnt_o != '1)) fix_cnt_o <= fix_cnt_o + CNT_W'(1);
      if (evt_i.bad_found)   last_bad_o <= frame_i;
      if (evt_i.start_acc)   unfixed_o <= 1'b0;
      else if (evt_i.unfixed) unfixed_o <= 1'b1;
    end
  end

endmodule

// File: rtl/frame_scrubber.sv
module frame_scrubber
  import scrub_pkg::*;
#(
  parameter int unsigned NUM_FRAMES  = 96,
  parameter int unsigned FRAME_WORDS = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned TIME_W      = 24,
  parameter int unsigned FRAME_W     = $clog2(NUM_FRAMES),
  parameter int unsigned WORD_W      = $clog2(FRAME_WORDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         reg_addr_i,
  input  logic               reg_we_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               cfg_req_o,
  output logic               cfg_we_o,
  output logic [FRAME_W-1:0] cfg_frame_o,
  output logic [WORD_W-1:0]  cfg_word_o,
  output logic [DATA_W-1:0]  cfg_wdata_o,
  input  logic               cfg_gnt_i,
  input  logic [DATA_W-1:0]  cfg_rdata_i,
  input  logic [DATA_W-1:0]  gold_rdata_i
);

  ctrl_t              ctrl;
  seq_evt_t           evt;
  logic               seq_busy, seq_at_bnd, unfixed;
  logic [CNT_W-1:0]   fix_cnt;
  logic [FRAME_W-1:0] last_bad;
  logic [TIME_W-1:0]  pass_cycles;

  scrub_regs #(.FRAME_W(FRAME_W), .CNT_W(CNT_W), .TIME_W(TIME_W)) u_regs (
    .clk_i, .rst_ni, .reg_addr_i, .reg_we_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(seq_busy), .unfixed_i(unfixed), .cur_frame_i(cfg_frame_o),
    .fix_cnt_i(fix_cnt), .last_bad_i(last_bad), .pass_cycles_i(pass_cycles),
    .ctrl_o(ctrl)
  );

  scrub_seq #(
    .NUM_FRAMES(NUM_FRAMES), .FRAME_WORDS(FRAME_WORDS), .DATA_W(DATA_W),
    .FRAME_W(FRAME_W), .WORD_W(WORD_W)
  ) u_seq (
    .clk_i, .rst_ni, .ctrl_i(ctrl),
    .cfg_req_o, .cfg_we_o, .cfg_frame_o, .cfg_word_o, .cfg_wdata_o,
    .cfg_gnt_i, .cfg_rdata_i, .gold_rdata_i,
    .busy_o(seq_busy), .at_bnd_o(seq_at_bnd), .evt_o(evt)
  );

  scrub_log #(.FRAME_W(FRAME_W), .CNT_W(CNT_W), .TIME_W(TIME_W)) u_log (
    .clk_i, .rst_ni, .evt_i(evt), .busy_i(seq_busy), .frame_i(cfg_frame_o),
    .fix_cnt_o(fix_cnt), .last_bad_o(last_bad), .unfixed_o(unfixed),
    .pass_cycles_o(pass_cycles)
  );

endmodule

// File: rtl/frame_scrubber_chk.sv
module frame_scrubber_chk #(
  parameter int unsigned NUM_FRAMES = 96,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned FRAME_W    = 7,
  parameter int unsigned WORD_W     = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_req_o,
  input logic               cfg_we_o,
  input logic               cfg_gnt_i,
  input logic [FRAME_W-1:0] cfg_frame_o,
  input logic [WORD_W-1:0]  cfg_word_o,
  input logic               busy_i,
  input logic               at_bnd_i,
  input logic [CNT_W-1:0]   fix_cnt_i,
  input logic [1:0]         mode_i
);

  localparam logic [FRAME_W-1:0] LAST_F = FRAME_W'(NUM_FRAMES - 1);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !cfg_req_o);

  assert_frame_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_frame_o <= LAST_F);

  assert_count_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fix_cnt_i == '1) |=> (fix_cnt_i == '1));

  assert_count_mono_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (fix_cnt_i >= $past(fix_cnt_i)));

  assert_halt_at_bnd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> $past(at_bnd_i));

  assert_mode_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> ($past(mode_i) == 2'd0));

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_o && !cfg_gnt_i) |=> (cfg_req_o && $stable(cfg_frame_o)
                                   && $stable(cfg_word_o) && $stable(cfg_we_o)));

endmodule

bind frame_scrubber frame_scrubber_chk #(
  .NUM_FRAMES(NUM_FRAMES), .CNT_W(CNT_W), .FRAME_W(FRAME_W), .WORD_W(WORD_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_req_o(cfg_req_o), .cfg_we_o(cfg_we_o),
  .cfg_gnt_i(cfg_gnt_i), .cfg_frame_o(cfg_frame_o), .cfg_word_o(cfg_word_o),
  .busy_i(seq_busy), .at_bnd_i(seq_at_bnd), .fix_cnt_i(fix_cnt), .mode_i(ctrl.mode)
);

// File: tb/tb_frame_scrubber.sv
`timescale 1ns/1ps
module tb_frame_scrubber;
  localparam int NF = 24, NW = 4, DW = 32, CW = 4, TW = 16, FW = 5, WW = 2;
  localparam int CLEAN_PASS = NF * (NW + 1);
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0, reg_rdata;
  logic          cfg_req, cfg_we, cfg_gnt;
  logic [FW-1:0] cfg_frame;
  logic [WW-1:0] cfg_word;
  logic [DW-1:0] cfg_wdata, cfg_rdata, gold_rdata;

  logic [DW-1:0] mem [NF*NW];
  logic stall_en = 1'b0, gnt_en = 1'b1;
  int   stuck_f = -1, n_wr = 0, n_req = 0;
  int   n_vec = 0, n_bad = 0, cyc = 0, exp_cnt = 0;
  bit   done = 0;

  frame_scrubber #(.NUM_FRAMES(NF), .FRAME_WORDS(NW), .DATA_W(DW), .CNT_W(CW), .TIME_W(TW)) dut (
    .clk_i(clk), .rst_ni, .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_frame_o(cfg_frame),
    .cfg_word_o(cfg_word), .cfg_wdata_o(cfg_wdata), .cfg_gnt_i(cfg_gnt),
    .cfg_rdata_i(cfg_rdata), .gold_rdata_i(gold_rdata));

  function automatic logic [31:0] gold_fn(int f, int w);
    return (32'h9E3779B9 * (f * NW + w + 1)) ^ (f << 20) ^ w;
  endfunction
  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  assign gold_rdata = gold_fn(int'(cfg_frame), int'(cfg_word));
  assign cfg_rdata  = mem[int'(cfg_frame) * NW + int'(cfg_word)]
                      ^ ((int'(cfg_frame) == stuck_f) ? 32'h1 : 32'h0);
  assign cfg_gnt    = cfg_req & gnt_en;

  // memory model: grant decided at negedge, write committed for the coming edge
  always @(negedge clk) begin
    gnt_en = stall_en ? (($urandom % 3) != 0) : 1'b1;
    if (cfg_req) n_req++;
    if (cfg_req && gnt_en && cfg_we) begin
      mem[int'(cfg_frame) * NW + int'(cfg_word)] = cfg_wdata;
      n_wr++;
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_idle(output int polls);
    logic [31:0] s;
    polls = 0;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd1, s); polls++;
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic run_pass();
    int p;
    wr(3'd0, 32'h1);
    wait_idle(p);
  endtask

  function automatic int bad_words(int f);
    int b = 0;
    for (int w = 0; w < NW; w++) if (mem[f*NW+w] != gold_fn(f, w)) b++;
    return b;
  endfunction
  function automatic int total_bad();
    int b = 0;
    for (int f = 0; f < NF; f++) b += bad_words(f);
    return b;
  endfunction

  initial begin
    logic [31:0] v;
    int k, maxf, x, y, p, seen, fixed_now;
    bit picked [NF];
    void'($urandom(32'd4711));
    for (int f = 0; f < NF; f++) for (int w = 0; w < NW; w++) mem[f*NW+w] = gold_fn(f, w);
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset values
    for (int a = 0; a < 6; a++) begin rd(3'(a), v); chk("R1 reset reg", int'(v), 0); end

    // R2/R3/R9: clean single pass
    n_wr = 0;
    run_pass();
    rd(3'd2, v); chk("R2 cur frame after pass", int'(v), NF-1);
    rd(3'd3, v); chk("R3 no repair on clean", int'(v), 0);
    chk("R3 no writes on clean", n_wr, 0);
    rd(3'd5, v); chk("R9 clean pass length", int'(v), CLEAN_PASS);

    // R3/R4/R9: random single-bit damage in distinct frames
    for (int r = 0; r < 3; r++) begin
      foreach (picked[i]) picked[i] = 0;
      k = 1 + ($urandom % 5); maxf = 0;
      for (int j = 0; j < k; j++) begin
        int f;
        do f = $urandom % NF; while (picked[f]);
        picked[f] = 1;
        if (f > maxf) maxf = f;
        mem[f*NW + ($urandom % NW)] ^= 32'h1 << ($urandom % 32);
      end
      n_wr = 0;
      run_pass();
      exp_cnt = sat(exp_cnt + k);
      rd(3'd3, v); chk("R4 repair count", int'(v), exp_cnt);
      rd(3'd4, v); chk("R4 last damaged frame", int'(v), maxf);
      chk("R3 full-frame rewrites", n_wr, k*NW);
      chk("R3 memory golden", total_bad(), 0);
      rd(3'd5, v); chk("R9 pass length with damage", int'(v), CLEAN_PASS + 2*NW*k);
    end

    // R10: stalled grants
    stall_en = 1'b1;
    mem[2*NW+1] ^= 32'h8000; mem[9*NW] ^= 32'h3; mem[(NF-1)*NW+NW-1] ^= 32'hFFFF_FFFF;
    run_pass();
    stall_en = 1'b0;
    exp_cnt = sat(exp_cnt + 3);
    chk("R10 golden under stalls", total_bad(), 0);
    rd(3'd3, v); chk("R10 repair count under stalls", int'(v), exp_cnt);

    // R5: frame that cannot be repaired
    y = $urandom % 10; x = 10 + ($urandom % 10);
    mem[y*NW + 2] ^= 32'h40; stuck_f = x;
    n_wr = 0;
    run_pass();
    exp_cnt = sat(exp_cnt + 1);
    rd(3'd1, v); chk("R5 unrepaired flag set", int'(v[1]), 1);
    rd(3'd3, v); chk("R5 count ignores unrepaired", int'(v), exp_cnt);
    chk("R5 no retry writes", n_wr, 2*NW);
    rd(3'd4, v); chk("R4 last damaged is unrepaired frame", int'(v), x);
    rd(3'd5, v); chk("R9 pass length with unrepaired", int'(v), CLEAN_PASS + 4*NW);
    stuck_f = -1;
    run_pass();
    rd(3'd1, v); chk("R5 flag cleared by start", int'(v), 0);

    // R8: start ignored outside scrub mode
    for (int m = 1; m <= 2; m++) begin
      n_req = 0;
      wr(3'd0, (32'(m) << 2) | 32'h1);
      repeat (8) @(negedge clk);
      rd(3'd1, v); chk("R8 busy stays low", int'(v[0]), 0);
      chk("R8 no requests", n_req, 0);
    end

    // R6: continuous wrap, then R7 halt by mode change
    wr(3'd0, 32'h3);
    seen = 0;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd2, v);
      if (int'(v) == NF-1) seen = 1;
      else if (seen && v == 0) break;
    end
    rd(3'd1, v); chk("R6 busy across wrap", int'(v[0]), 1);
    for (int w = 0; w < NW; w++) mem[3*NW+w] ^= 32'h0F0F_0001;
    repeat (3 * (CLEAN_PASS + 2*NW)) @(negedge clk);
    chk("R6 later pass repairs frame", bad_words(3), 0);
    exp_cnt = sat(exp_cnt + 1);
    wr(3'd0, 32'h6);
    wait_idle(p);
    rd(3'd1, v); chk("R7 idle after mode change", int'(v[0]), 0);
    chk("R7 mode halt within one frame", int'(p <= 3*NW+6), 1);

    // R7: stop during a run with every frame fully damaged
    for (int f = 0; f < NF; f++) for (int w = 0; w < NW; w++) mem[f*NW+w] ^= 32'hA5A5_0000 | f;
    wr(3'd0, 32'h3);
    repeat (20 + ($urandom % 200)) @(negedge clk);
    wr(3'd0, 32'h12);
    wait_idle(p);
    chk("R7 stop within one frame", int'(p <= 3*NW+6), 1);
    fixed_now = 0;
    for (int f = 0; f < NF; f++) begin
      int b = bad_words(f);
      chk("R7 frame whole or untouched", int'(b == 0 || b == NW), 1);
      if (b == 0) fixed_now++;
    end
    exp_cnt = sat(exp_cnt + fixed_now);
    rd(3'd3, v); chk("R4 count after stop", int'(v), exp_cnt);

    // R4 saturation and R9 fully damaged pass
    for (int f = 0; f < NF; f++) mem[f*NW + (f % NW)] ^= 32'h100;
    run_pass();
    for (int f = 0; f < NF; f++) for (int w = 0; w < NW; w++) mem[f*NW+w] = gold_fn(f, w);
    run_pass();
    rd(3'd3, v); chk("R4 count saturates", int'(v), CMAX);

    for (int f = 0; f < NF; f++) mem[f*NW] ^= 32'h2;
    run_pass();
    rd(3'd5, v); chk("R9 all frames damaged", int'(v), CLEAN_PASS + 2*NW*NF);
    rd(3'd3, v); chk("R4 count held at max", int'(v), CMAX);

    done = 1;
    summary();
    $finish;
  end
endmodule